// File: doc/BRIEF.md
# Register File with Rename Tags

This block holds the eight architectural integer registers of a small out-of-order core that schedules dynamically and does not speculate. A rename tag sits beside each 16-bit value. The tag names the in-flight instruction that will produce the register's next value. A tag of all ones means no write is outstanding, so the stored value is current. Tag zero is never handed out, and the usable tags start at one.

At issue, two source ports return either a value or the tag of the value's producer. In the same cycle, one rename port records the issuing instruction's tag against its destination register. A jump-and-link instruction writes its return address to register 1 by implication, so a link flag sends the rename to register 1. When a result appears on the broadcast bus, every register still waiting on that tag takes the data and goes back to the empty tag. A register that was renamed again since then keeps its newer tag. Register 0 always reads as zero and takes no renames.

Top module: `rfile_rename`

## Requirements
- R1: After reset every register reads value 0 and tag 4'hF, the empty tag.
- R2: Register 0 reads value 0 with the empty tag at all times. Renames aimed at it have no effect on it, and broadcasts have no effect on it.
- R3: Each of the two source ports returns, in the same cycle, the value and the tag of the register its index selects. A returned tag of 4'hF means the value is valid.
- R4: An issue with `iss_valid` high, `iss_link` low and destination index d, where d is not 0, sets register d's tag to `iss_tag` from the next cycle on. Register d's value stays unchanged.
- R5: An issue with `iss_link` high renames register 1 with `iss_tag` and ignores `iss_dst`.
- R6: A broadcast with `bc_valid` high writes `bc_data` into every register whose stored tag equals `bc_tag`, and sets those tags to 4'hF in the next cycle. Registers holding other tags do not change.
- R7: A register that has been renamed again keeps its newer tag and its value when the older tag is broadcast.
- R8: When a rename and a matching broadcast hit the same register in the same cycle, the register takes the broadcast data and the new rename tag.
- R9: A source read of a register whose stored tag matches the broadcast in the current cycle returns `bc_data` and the empty tag.
- R10: A rename that carries tag 0 or 4'hF is ignored. A broadcast with tag 4'hF changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a_idx | input | 3 | Register index, source port A |
| src_a_val | output | 16 | Value, source port A |
| src_a_tag | output | 4 | Producer tag, source port A (4'hF = ready) |
| src_b_idx | input | 3 | Register index, source port B |
| src_b_val | output | 16 | Value, source port B |
| src_b_tag | output | 4 | Producer tag, source port B (4'hF = ready) |
| iss_valid | input | 1 | Rename request this cycle |
| iss_link | input | 1 | Rename register 1 (link) instead of `iss_dst` |
| iss_dst | input | 3 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing instruction |
| bc_valid | input | 1 | Result broadcast this cycle |
| bc_tag | input | 4 | Tag of the broadcast result |
| bc_data | input | 16 | Broadcast result value |

## Verification
The bound checker watches the architectural state on every cycle. It checks that register 0 stays pinned, that a legal rename lands its tag in the right entry, that the link flag redirects the rename to register 1, and that a matching broadcast clears the tag and loads the data. It also checks that a source port never shows a tag being broadcast in that cycle, and that reserved rename tags leave the state alone. The bench's scenarios are what show the behaviour across several cycles: a newer rename surviving the broadcast of an older tag, rename and broadcast colliding in one cycle, and long pseudo-random mixes of renames and broadcasts compared against a value model.

// File: rtl/rft_pkg.sv
package rft_pkg;
    localparam int RFT_NREG   = 8;
    localparam int RFT_DATA_W = 16;
    localparam int RFT_TAG_W  = 4;
    localparam int RFT_LINK   = 1;
endpackage

// File: rtl/rft_read_port.sv
module rft_read_port #(
    parameter int NREG   = rft_pkg::RFT_NREG,
    parameter int DATA_W = rft_pkg::RFT_DATA_W,
    parameter int TAG_W  = rft_pkg::RFT_TAG_W,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [IDX_W-1:0]             idx,
    input  logic [NREG-1:0][DATA_W-1:0]  val_q,
    input  logic [NREG-1:0][TAG_W-1:0]   tag_q,
    input  logic                         bc_valid,
    input  logic [TAG_W-1:0]             bc_tag,
    input  logic [DATA_W-1:0]            bc_data,
    output logic [DATA_W-1:0]            val,
    output logic [TAG_W-1:0]             tag
);
    localparam logic [TAG_W-1:0] TAG_NONE = {TAG_W{1'b1}};

    logic [TAG_W-1:0] cur_tag;
    logic             fwd_hit;

    always_comb begin
        cur_tag = tag_q[idx];
        fwd_hit = bc_valid && (cur_tag != TAG_NONE) && (cur_tag == bc_tag);
        if (idx == '0) begin
            val = '0;
            tag = TAG_NONE;
        end else if (fwd_hit) begin
            val = bc_data;
            tag = TAG_NONE;
        end else begin
            val = val_q[idx];
            tag = cur_tag;
        end
    end
endmodule

// File: rtl/rft_dest_decode.sv
module rft_dest_decode #(
    parameter int NREG     = rft_pkg::RFT_NREG,
    parameter int TAG_W    = rft_pkg::RFT_TAG_W,
    parameter int LINK_REG = rft_pkg::RFT_LINK,
    localparam int IDX_W   = $clog2(NREG)
) (
    input  logic             iss_valid,
    input  logic             iss_link,
    input  logic [IDX_W-1:0] iss_dst,
    input  logic [TAG_W-1:0] iss_tag,
    output logic [NREG-1:0]  hit
);
    localparam logic [TAG_W-1:0] TAG_NONE = {TAG_W{1'b1}};

    logic [IDX_W-1:0] target;
    logic             go;

    assign target = iss_link ? IDX_W'(LINK_REG) : iss_dst;
    assign go     = iss_valid && (iss_tag != '0) && (iss_tag != TAG_NONE);

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        if (g == 0) begin : g_zero
            assign hit[g] = 1'b0;
        end else begin : g_reg
            assign hit[g] = go && (target == IDX_W'(g));
        end
    end
endmodule

// File: rtl/rfile_rename.sv
module rfile_rename #(
    parameter int NREG     = rft_pkg::RFT_NREG,
    parameter int DATA_W   = rft_pkg::RFT_DATA_W,
    parameter int TAG_W    = rft_pkg::RFT_TAG_W,
    parameter int LINK_REG = rft_pkg::RFT_LINK,
    localparam int IDX_W   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic [DATA_W-1:0] src_a_val,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic [DATA_W-1:0] src_b_val,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              iss_valid,
    input  logic              iss_link,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data
);
    localparam logic [TAG_W-1:0] TAG_NONE = {TAG_W{1'b1}};

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] val;
        logic [NREG-1:0][TAG_W-1:0]  tag;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [NREG-1:0]             ren_hit;
    logic [NREG-1:0][DATA_W-1:0] val_q;
    logic [NREG-1:0][TAG_W-1:0]  tag_q;

    assign val_q = st_q.val;
    assign tag_q = st_q.tag;

    rft_dest_decode #(.NREG(NREG), .TAG_W(TAG_W), .LINK_REG(LINK_REG)) u_dec (
        .iss_valid (iss_valid),
        .iss_link  (iss_link),
        .iss_dst   (iss_dst),
        .iss_tag   (iss_tag),
        .hit       (ren_hit)
    );

    rft_read_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd_a (
        .idx      (src_a_idx),
        .val_q    (val_q),
        .tag_q    (tag_q),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .val      (src_a_val),
        .tag      (src_a_tag)
    );

    rft_read_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd_b (
        .idx      (src_b_idx),
        .val_q    (val_q),
        .tag_q    (tag_q),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .val      (src_b_val),
        .tag      (src_b_tag)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NREG; i++) begin
            if (bc_valid && (st_q.tag[i] != TAG_NONE) && (st_q.tag[i] == bc_tag)) begin
                st_d.val[i] = bc_data;
                st_d.tag[i] = TAG_NONE;
            end
            if (ren_hit[i]) begin
                st_d.tag[i] = iss_tag;
            end
        end
        st_d.val[0] = '0;
        st_d.tag[0] = TAG_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                st_q.val[i] <= '0;
                st_q.tag[i] <= TAG_NONE;
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rft_checker.sv
module rft_checker #(
    parameter int NREG     = rft_pkg::RFT_NREG,
    parameter int DATA_W   = rft_pkg::RFT_DATA_W,
    parameter int TAG_W    = rft_pkg::RFT_TAG_W,
    parameter int LINK_REG = rft_pkg::RFT_LINK,
    localparam int IDX_W   = $clog2(NREG)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [IDX_W-1:0]            src_a_idx,
    input logic [DATA_W-1:0]           src_a_val,
    input logic [TAG_W-1:0]            src_a_tag,
    input logic [IDX_W-1:0]            src_b_idx,
    input logic [DATA_W-1:0]           src_b_val,
    input logic [TAG_W-1:0]            src_b_tag,
    input logic                        iss_valid,
    input logic                        iss_link,
    input logic [IDX_W-1:0]            iss_dst,
    input logic [TAG_W-1:0]            iss_tag,
    input logic                        bc_valid,
    input logic [TAG_W-1:0]            bc_tag,
    input logic [DATA_W-1:0]           bc_data,
    input logic [NREG-1:0][DATA_W-1:0] val_q,
    input logic [NREG-1:0][TAG_W-1:0]  tag_q
);
    localparam logic [TAG_W-1:0] TAG_NONE = {TAG_W{1'b1}};

    logic             tag_ok;
    logic [IDX_W-1:0] ren_tgt;

    assign tag_ok  = (iss_tag != '0) && (iss_tag != TAG_NONE);
    assign ren_tgt = iss_link ? IDX_W'(LINK_REG) : iss_dst;

    assert_r0_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q[0] == '0) && (tag_q[0] == TAG_NONE));

    assert_r0_port_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == '0) |-> (src_a_val == '0) && (src_a_tag == TAG_NONE));

    assert_r0_port_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b_idx == '0) |-> (src_b_val == '0) && (src_b_tag == TAG_NONE));

    assert_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_link && tag_ok) |=> (tag_q[LINK_REG] == $past(iss_tag)));

    assert_fwd_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && (src_a_tag != TAG_NONE)) |-> (src_a_tag != bc_tag));

    assert_fwd_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && (src_b_tag != TAG_NONE)) |-> (src_b_tag != bc_tag));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !tag_ok && !bc_valid) |=> ($stable(tag_q) && $stable(val_q)));

    assert_bc_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && (bc_tag == TAG_NONE) && !iss_valid) |=> ($stable(tag_q) && $stable(val_q)));

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        assert_rename_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && tag_ok && (ren_tgt == IDX_W'(g)))
            |=> (tag_q[g] == $past(iss_tag)));

        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && (tag_q[g] != TAG_NONE) && (tag_q[g] == bc_tag)
             && !(iss_valid && tag_ok && (ren_tgt == IDX_W'(g))))
            |=> ((tag_q[g] == TAG_NONE) && (val_q[g] == $past(bc_data))));

        assert_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && (tag_q[g] != TAG_NONE) && (tag_q[g] == bc_tag)
             && iss_valid && tag_ok && (ren_tgt == IDX_W'(g)))
            |=> (val_q[g] == $past(bc_data)));
    end
endmodule

bind rfile_rename rft_checker #(
    .NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W), .LINK_REG(LINK_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a_idx (src_a_idx),
    .src_a_val (src_a_val),
    .src_a_tag (src_a_tag),
    .src_b_idx (src_b_idx),
    .src_b_val (src_b_val),
    .src_b_tag (src_b_tag),
    .iss_valid (iss_valid),
    .iss_link  (iss_link),
    .iss_dst   (iss_dst),
    .iss_tag   (iss_tag),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .bc_data   (bc_data),
    .val_q     (val_q),
    .tag_q     (tag_q)
);

// File: tb/sim_rfile_rename.sv
module sim_rfile_rename;
    localparam logic [3:0] NONE = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_a_idx = '0, src_b_idx = '0;
    logic [15:0] src_a_val, src_b_val;
    logic [3:0]  src_a_tag, src_b_tag;
    logic        iss_valid = 1'b0, iss_link = 1'b0;
    logic [2:0]  iss_dst = '0;
    logic [3:0]  iss_tag = '0;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [15:0] bc_data = '0;

    logic [15:0] mval [8];
    logic [3:0]  mtag [8];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rfile_rename u0 (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(src_a_idx), .src_a_val(src_a_val), .src_a_tag(src_a_tag),
        .src_b_idx(src_b_idx), .src_b_val(src_b_val), .src_b_tag(src_b_tag),
        .iss_valid(iss_valid), .iss_link(iss_link), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data)
    );

    function automatic void expect_read(input int idx, output logic [15:0] v, output logic [3:0] t);
        if (idx == 0) begin
            v = '0; t = NONE;
        end else if (bc_valid && mtag[idx] != NONE && mtag[idx] == bc_tag) begin
            v = bc_data; t = NONE;
        end else begin
            v = mval[idx]; t = mtag[idx];
        end
    endfunction

    task automatic compare(input string req, input int idx, input logic [15:0] av, input logic [3:0] at,
                           input logic [15:0] ev, input logic [3:0] et);
        checks++;
        if (av !== ev || at !== et) begin
            errors++;
            $display("FAIL %s reg %0d: got val %h tag %h, expected val %h tag %h", req, idx, av, at, ev, et);
        end
    endtask

    task automatic check_all(input string req);
        logic [15:0] ev;
        logic [3:0]  et;
        for (int k = 0; k < 4; k++) begin
            src_a_idx = 3'(k);
            src_b_idx = 3'(k + 4);
            #1;
            expect_read(k, ev, et);
            compare(req, k, src_a_val, src_a_tag, ev, et);
            expect_read(k + 4, ev, et);
            compare(req, k + 4, src_b_val, src_b_tag, ev, et);
        end
    endtask

    task automatic expect_reg(input string req, input int idx, input logic [15:0] ev, input logic [3:0] et);
        src_a_idx = 3'(idx);
        #1;
        compare(req, idx, src_a_val, src_a_tag, ev, et);
    endtask

    task automatic drive(input logic iv, input logic lk, input int dst, input logic [3:0] it,
                         input logic bv, input logic [3:0] bt, input logic [15:0] bd);
        iss_valid = iv; iss_link = lk; iss_dst = 3'(dst); iss_tag = it;
        bc_valid = bv; bc_tag = bt; bc_data = bd;
    endtask

    task automatic tick();
        logic [15:0] nv [8];
        logic [3:0]  nt [8];
        int tgt;
        for (int i = 0; i < 8; i++) begin
            nv[i] = mval[i]; nt[i] = mtag[i];
        end
        for (int i = 1; i < 8; i++) begin
            if (bc_valid && mtag[i] != NONE && mtag[i] == bc_tag) begin
                nv[i] = bc_data; nt[i] = NONE;
            end
        end
        tgt = iss_link ? 1 : int'(iss_dst);
        if (iss_valid && iss_tag != 4'h0 && iss_tag != NONE && tgt != 0) nt[tgt] = iss_tag;
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            mval[i] = nv[i]; mtag[i] = nt[i];
        end
        @(negedge clk);
        drive(0, 0, 0, 4'h0, 0, 4'h0, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] keep;
        for (int i = 0; i < 8; i++) begin
            mval[i] = '0; mtag[i] = NONE;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_all("R1");

        // R4 / R2: rename every register, tag r+1
        for (int r = 0; r < 8; r++) begin
            drive(1, 0, r, 4'(r + 1), 0, 4'h0, 16'h0);
            tick();
            if (r != 0) expect_reg("R4", r, 16'h0, 4'(r + 1));
        end
        check_all("R4");
        expect_reg("R2", 0, 16'h0, NONE);

        // R9 during broadcast, R6 after it
        for (int r = 1; r < 8; r++) begin
            drive(0, 0, 0, 4'h0, 1, 4'(r + 1), 16'h1000 * 16'(r) + 16'(r));
            check_all("R9");
            tick();
            expect_reg("R6", r, 16'h1000 * 16'(r) + 16'(r), NONE);
        end
        // broadcast tag 1 (offered to R0 earlier) must change nothing
        drive(0, 0, 0, 4'h0, 1, 4'h1, 16'h5555);
        tick();
        check_all("R2");

        // R5: link rename goes to R1, not iss_dst
        keep = mval[5];
        drive(1, 1, 5, 4'h9, 0, 4'h0, 16'h0);
        tick();
        expect_reg("R5", 1, 16'h1001, 4'h9);
        expect_reg("R5", 5, keep, NONE);
        drive(0, 0, 0, 4'h0, 1, 4'h9, 16'h0042);
        tick();
        expect_reg("R5", 1, 16'h0042, NONE);

        // R7: older broadcast leaves newer rename
        keep = mval[3];
        drive(1, 0, 3, 4'h2, 0, 4'h0, 16'h0);
        tick();
        drive(1, 0, 3, 4'h3, 0, 4'h0, 16'h0);
        tick();
        drive(0, 0, 0, 4'h0, 1, 4'h2, 16'hDEAD);
        tick();
        expect_reg("R7", 3, keep, 4'h3);
        drive(0, 0, 0, 4'h0, 1, 4'h3, 16'hBEEF);
        tick();
        expect_reg("R7", 3, 16'hBEEF, NONE);

        // R8: rename and matching broadcast in one cycle
        drive(1, 0, 4, 4'h4, 0, 4'h0, 16'h0);
        tick();
        drive(1, 0, 4, 4'h6, 1, 4'h4, 16'h1234);
        tick();
        expect_reg("R8", 4, 16'h1234, 4'h6);

        // R10: reserved tags
        keep = mval[2];
        drive(1, 0, 2, 4'h0, 0, 4'h0, 16'h0);
        tick();
        expect_reg("R10", 2, keep, NONE);
        drive(1, 0, 2, NONE, 0, 4'h0, 16'h0);
        tick();
        expect_reg("R10", 2, keep, NONE);
        drive(0, 0, 0, 4'h0, 1, NONE, 16'hFFFF);
        tick();
        check_all("R10");
        expect_reg("R10", 7, 16'h7007, NONE);

        // R3: pseudo-random mix checked every cycle
        lfsr = 16'hACE1;
        for (int c = 0; c < 600; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0], lfsr[1] & lfsr[2], int'(lfsr[5:3]), lfsr[9:6],
                  lfsr[10], mtag[lfsr[13:11]], lfsr ^ 16'(c));
            check_all("R3");
            tick();
        end
        check_all("R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end
endmodule